// File: doc/BRIEF.md
# Latched One-of-Eight Line Decoder

This block turns a three-bit binary select value into one of eight select lines, for picking a memory bank or an I/O device, or for steering a single data bit onto one of eight wires. A hold input freezes the select value so the outputs stay put while the select bus moves on to other work. Two enables of opposite sense gate every output. Wider decoders are built by chaining instances, and either enable can act as the data input of a demultiplexer.

The hold stage is a register clocked by the system clock. While hold is low the register takes the select bus on every edge and the decoder reads the bus directly, so the outputs follow the bus within the same cycle. While hold is high the decoder reads the register, which keeps the value from the last edge at which hold was low. A parameter sets whether the chosen line is driven high, with the other lines low, or driven low, with the other lines high.

Top module: `latched_decoder`

## Requirements
- R1: While both enables are active, exactly one of the eight output lines is at the asserted level.
- R2: While hold is high, changes on the select bus have no effect on the outputs. The selected line is the select value present at the last rising clock edge at which hold was low.
- R3: While hold is low, the asserted line index equals the current select value, with bit 0 of the select bus as its least significant bit, in the same cycle and with no clock edge needed.
- R4: An output can assert only when the active-low enable is 0 and the active-high enable is 1.
- R5: If either enable is inactive, all eight outputs sit at the idle level.
- R6: With POLARITY = POL_HIGH the asserted level is 1 and the idle level is 0. With POL_LOW the asserted level is 0 and the idle level is 1.
- R7: If one enable is held active and data is driven on the other, the selected line carries that data: true on the line when the enable data is in its active state, idle otherwise.
- R8: Synchronous active-high reset clears the held select value to 0, so with hold high after reset, line 0 is the selected line.
- R9: Two instances form a 4-to-16 decoder when address bit 3 drives the active-low enable of the lower instance and the active-high enable of the upper instance.
- R10: While hold is high, turning the enables off and back on returns the output to the same held line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_i | input | SEL_W (3) | Binary select value |
| hold_i | input | 1 | 1 = keep the stored select value, 0 = transparent |
| en_n_i | input | 1 | Active-low output enable |
| en_i | input | 1 | Active-high output enable |
| out_o | output | 2**SEL_W (8) | Decoded select lines |

## Verification
A stale or corrupted held value shows up as a wrong asserted line in the first cycle after hold goes high. The bench reads the lines right after it raises hold and again after each later change on the select bus. A faulty capture enable makes the outputs drift with the bus during hold, and each bus change exposes that within the same cycle. Gating or polarity errors show up at once as extra, missing or inverted lines. The exhaustive sweeps over select values and enable combinations reach every one of these cases.

// File: rtl/latdec_pkg.sv
package latdec_pkg;

    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } polarity_e;

    typedef struct packed {
        logic en_n;
        logic en;
    } gate_t;

    function automatic logic gate_open(input gate_t g);
        return (!g.en_n) && g.en;
    endfunction

endpackage

// File: rtl/addr_hold.sv
module addr_hold #(
    parameter int SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             hold_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [SEL_W-1:0] sel_o
);
    logic [SEL_W-1:0] kept_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            kept_q <= '0;
        end else if (!hold_i) begin
            kept_q <= sel_i;
        end
    end

    always_comb begin
        sel_o = hold_i ? kept_q : sel_i;
    end
endmodule

// File: rtl/line_decode.sv
module line_decode #(
    parameter int SEL_W = 3,
    localparam int OUT_N = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic             open_i,
    output logic [OUT_N-1:0] hit_o
);
    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign hit_o[i] = open_i && (sel_i == SEL_W'(i));
    end
endmodule

// File: rtl/out_gate.sv
module out_gate #(
    parameter int OUT_N = 8,
    parameter latdec_pkg::polarity_e POLARITY = latdec_pkg::POL_HIGH
) (
    input  logic [OUT_N-1:0] hit_i,
    output logic [OUT_N-1:0] out_o
);
    if (POLARITY == latdec_pkg::POL_HIGH) begin : g_high
        assign out_o = hit_i;
    end else begin : g_low
        assign out_o = ~hit_i;
    end
endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
    parameter int SEL_W = 3,
    parameter latdec_pkg::polarity_e POLARITY = latdec_pkg::POL_HIGH,
    localparam int OUT_N = 1 << SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             hold_i,
    input  logic             en_n_i,
    input  logic             en_i,
    output logic [OUT_N-1:0] out_o
);
    import latdec_pkg::*;

    logic [SEL_W-1:0] sel_eff;
    logic [OUT_N-1:0] hit;
    gate_t            gate;
    logic             open;

    always_comb begin
        gate.en_n = en_n_i;
        gate.en   = en_i;
        open      = gate_open(gate);
    end

    addr_hold #(.SEL_W(SEL_W)) u_hold (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .hold_i(hold_i),
        .sel_i (sel_i),
        .sel_o (sel_eff)
    );

    line_decode #(.SEL_W(SEL_W)) u_dec (
        .sel_i (sel_eff),
        .open_i(open),
        .hit_o (hit)
    );

    out_gate #(.OUT_N(OUT_N), .POLARITY(POLARITY)) u_gate (
        .hit_i(hit),
        .out_o(out_o)
    );
endmodule

// File: rtl/latdec_checker.sv
module latdec_checker #(
    parameter int SEL_W = 3,
    parameter latdec_pkg::polarity_e POLARITY = latdec_pkg::POL_HIGH,
    localparam int OUT_N = 1 << SEL_W
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [SEL_W-1:0] sel_i,
    input logic             hold_i,
    input logic             en_n_i,
    input logic             en_i,
    input logic [OUT_N-1:0] out_o
);
    logic [OUT_N-1:0] asserted;
    logic             active;

    always_comb begin
        asserted = (POLARITY == latdec_pkg::POL_HIGH) ? out_o : ~out_o;
        active   = !en_n_i && en_i;
    end

    AST_ONE_LINE: assert property (@(posedge clk_i) disable iff (rst_i)
        active |-> ($countones(asserted) == 1)); // R1

    AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        !active |-> (asserted == '0)); // R5

    AST_FOLLOW_SEL: assert property (@(posedge clk_i) disable iff (rst_i)
        (active && !hold_i) |-> (asserted == (OUT_N'(1) << sel_i))); // R3

    AST_HOLD_STEADY: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && hold_i && $past(hold_i) && $stable({en_n_i, en_i}))
            |-> $stable(out_o)); // R2
endmodule

bind latched_decoder latdec_checker #(
    .SEL_W   (SEL_W),
    .POLARITY(POLARITY)
) u_chk (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .sel_i (sel_i),
    .hold_i(hold_i),
    .en_n_i(en_n_i),
    .en_i  (en_i),
    .out_o (out_o)
);

// File: tb/latched_decoder_tb.sv
module latched_decoder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = '0;
    logic       hold = 1'b0;
    logic       en_n = 1'b0;
    logic       en = 1'b1;
    logic [7:0] out_hi;
    logic [7:0] out_lo;
    logic [3:0] addr = '0;
    logic [7:0] casc_lo;
    logic [7:0] casc_hi;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    latched_decoder #(.SEL_W(3), .POLARITY(latdec_pkg::POL_HIGH)) u_dut (
        .clk_i(clk), .rst_i(rst), .sel_i(sel), .hold_i(hold),
        .en_n_i(en_n), .en_i(en), .out_o(out_hi));

    latched_decoder #(.SEL_W(3), .POLARITY(latdec_pkg::POL_LOW)) u_dut_lo (
        .clk_i(clk), .rst_i(rst), .sel_i(sel), .hold_i(hold),
        .en_n_i(en_n), .en_i(en), .out_o(out_lo));

    latched_decoder #(.SEL_W(3), .POLARITY(latdec_pkg::POL_HIGH)) u_casc_lo (
        .clk_i(clk), .rst_i(rst), .sel_i(addr[2:0]), .hold_i(1'b0),
        .en_n_i(addr[3]), .en_i(1'b1), .out_o(casc_lo));

    latched_decoder #(.SEL_W(3), .POLARITY(latdec_pkg::POL_HIGH)) u_casc_hi (
        .clk_i(clk), .rst_i(rst), .sel_i(addr[2:0]), .hold_i(1'b0),
        .en_n_i(1'b0), .en_i(addr[3]), .out_o(casc_hi));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Both polarities compared against the active-high expectation line
    task automatic check_pair(input string req, input logic [7:0] exp_hit);
        check({req, " high"}, {8'h00, out_hi}, {8'h00, exp_hit});
        check({req, " low"},  {8'h00, out_lo}, {8'h00, ~exp_hit});
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R8: reset with hold high, select bus nonzero
        hold = 1'b1;
        sel  = 3'd5;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1 check_pair("R8", 8'h01);

        // R3 R1 R4 R5 R6: transparent sweep over selects and enable pairs
        hold = 1'b0;
        for (int s = 0; s < 8; s++) begin
            for (int e = 0; e < 4; e++) begin
                @(negedge clk);
                sel  = 3'(s);
                en_n = e[1];
                en   = e[0];
                #1;
                if (!e[1] && e[0]) begin
                    check_pair("R3", 8'(1 << s));
                    check("R1", 16'($countones(out_hi)), 16'd1);
                end else begin
                    check_pair("R5", 8'h00);
                end
                check("R4", 16'(out_hi != 8'h00), 16'(!e[1] && e[0]));
                check("R6", 16'(out_lo == ~out_hi), 16'd1);
            end
        end

        // R2: hold freezes the selection captured at the last low-hold edge
        en_n = 1'b0;
        en   = 1'b1;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            hold = 1'b0;
            sel  = 3'(s);
            @(negedge clk);
            hold = 1'b1;
            for (int t = 0; t < 8; t++) begin
                sel = 3'(t);
                #1 check_pair("R2", 8'(1 << s));
                @(negedge clk);
            end
            // R10: enables off then on while held
            en = 1'b0;
            #1 check_pair("R10 off", 8'h00);
            @(negedge clk);
            en = 1'b1;
            #1 check_pair("R10", 8'(1 << s));
        end

        // R7: demultiplex data on either enable
        @(negedge clk);
        hold = 1'b0;
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 2; d++) begin
                @(negedge clk);
                sel  = 3'(s);
                en_n = 1'b0;
                en   = d[0];
                #1 check_pair("R7 en", d[0] ? 8'(1 << s) : 8'h00);
                en   = 1'b1;
                en_n = !d[0];
                #1 check_pair("R7 en_n", d[0] ? 8'(1 << s) : 8'h00);
            end
        end

        // R9: cascaded 4-to-16
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            addr = 4'(a);
            #1 check("R9", {casc_hi, casc_lo}, 16'(1 << a));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule